// File: doc/BRIEF.md
# Inter-Processor Doorbell Hub

The hub lets one processor signal other agents, and lets agents signal it back. Eleven agent channels are spread over fixed, sparse bit positions of a 32-bit word. A bus write to the fire register sends a one-cycle pulse to each selected agent. Doorbell levels arriving from other agents are caught in a sticky pending register. One registered interrupt line is raised while any pending channel is also enabled.

The enable state lives in a mask register that software cannot write directly. Software clears mask bits through an unmask register and sets them through a mask-set register. A watch register samples 32 observation inputs. Eleven watch outputs show the pending state of each channel. The bus carries full 32-bit words only. Each cycle it presents an address, a write enable and write data, and the read data is combinational from the current register state.

Top module: `ipi_hub`

## Requirements
- R1: Only bits 0, 8, 9, 16..19 and 24..27 (mask 0x0F0F0301) are implemented. Every other bit of every register reads as zero, and writes to it have no effect.
- R2: A write to the fire register (byte offset 0x00) drives trig_out high for exactly the cycle after the write. Output bit k matches word bit position k of the list 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27. The fire register always reads 0.
- R3: The pending register (offset 0x10) sets a bit on the clock edge where the matching bell_in bit is high. The bit holds until a write of 1 to that bit at 0x10. Writing 0 leaves the bit unchanged.
- R4: When a bell_in bit is high on the same edge as a clearing write to that bit, the pending bit ends set.
- R5: The mask register (offset 0x14) resets to 0x0F0F0301, and bus writes to it have no effect.
- R6: Writing the unmask register (0x18) clears the mask bits written as 1. Writing the mask-set register (0x1C) sets the mask bits written as 1. Both registers read 0.
- R7: irq_out is registered. After each edge it equals the OR over bits of (pending AND NOT mask), as those registers stood before that edge.
- R8: The watch register (offset 0x04) reads the value that watch_in held at the previous clock edge, restricted to the implemented bits. Bus writes to it have no effect.
- R9: Each bit of watch_out equals the current pending bit of its channel, using the channel order of R2.
- R10: A read of any unlisted word offset, such as 0x08 or 0x0C, returns 0. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| bell_in | input | 32 | Incoming doorbell levels |
| watch_in | input | 32 | Observation levels from agents |
| trig_out | output | 11 | One-cycle doorbell pulses to agents |
| watch_out | output | 11 | Per-channel pending state |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that every bus access is a whole word and that a write lasts one cycle per bus_we. They also assume that bell_in and watch_in are synchronous to clk. The stimulus always drives word-aligned addresses, and it changes every input only at the falling edge. The bell inputs are sparse random words that include reserved bits. Directed sequences add the collision between a set and a clear, and the attempt to write the mask register directly.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int NCH  = 11;
    localparam int DW   = 32;
    localparam logic [DW-1:0] IMPL_MASK = 32'h0F0F0301;

    // word indices of the register map
    localparam int W_FIRE  = 0;
    localparam int W_WATCH = 1;
    localparam int W_PEND  = 4;
    localparam int W_MASK  = 5;
    localparam int W_UNMSK = 6;
    localparam int W_MSET  = 7;

    // bit position of channel i inside the word
    function automatic int chan_pos(input int i);
        if (i == 0)     return 0;
        else if (i < 3) return 7 + i;
        else if (i < 7) return 13 + i;
        else            return 17 + i;
    endfunction

    function automatic logic [NCH-1:0] gather(input logic [DW-1:0] w);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = w[chan_pos(i)];
        return r;
    endfunction

    typedef struct packed {
        logic [NCH-1:0] fire;
        logic [DW-1:0]  pend;
        logic [DW-1:0]  mask;
        logic [DW-1:0]  watch;
        logic           irq;
    } hub_state_t;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic              wr_fire_o,
    output logic              wr_pend_o,
    output logic              wr_unmsk_o,
    output logic              wr_mset_o,
    output logic              rd_watch_o,
    output logic              rd_pend_o,
    output logic              rd_mask_o
);
    localparam int WW = ADDR_W - 2;
    logic [WW-1:0] word;

    always_comb begin
        word       = addr_i[ADDR_W-1:2];
        rd_watch_o = (word == WW'(W_WATCH));
        rd_pend_o  = (word == WW'(W_PEND));
        rd_mask_o  = (word == WW'(W_MASK));
        wr_fire_o  = we_i && (word == WW'(W_FIRE));
        wr_pend_o  = we_i && rd_pend_o;
        wr_unmsk_o = we_i && (word == WW'(W_UNMSK));
        wr_mset_o  = we_i && (word == WW'(W_MSET));
    end
endmodule

// File: rtl/ipi_bit_gather.sv
module ipi_bit_gather
    import ipi_pkg::*;
(
    input  logic [DW-1:0]  word_i,
    output logic [NCH-1:0] chan_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int P = chan_pos(g);
        assign chan_o[g] = word_i[P];
    end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       bell_in,
    input  logic [31:0]       watch_in,
    output logic [10:0]       trig_out,
    output logic [10:0]       watch_out,
    output logic              irq_out
);
    hub_state_t st_d, st_q;
    logic wr_fire, wr_pend, wr_unmsk, wr_mset;
    logic rd_watch, rd_pend, rd_mask;
    logic [NCH-1:0] fire_bits;
    logic [DW-1:0]  wmask;
    logic [DW-1:0]  mask_q;

    ipi_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .wr_fire_o  (wr_fire),
        .wr_pend_o  (wr_pend),
        .wr_unmsk_o (wr_unmsk),
        .wr_mset_o  (wr_mset),
        .rd_watch_o (rd_watch),
        .rd_pend_o  (rd_pend),
        .rd_mask_o  (rd_mask)
    );

    ipi_bit_gather u_fire_map (.word_i(bus_wdata), .chan_o(fire_bits));
    ipi_bit_gather u_pend_map (.word_i(st_q.pend), .chan_o(watch_out));

    always_comb begin
        wmask = bus_wdata & IMPL_MASK;
        st_d  = st_q;
        st_d.fire = wr_fire ? fire_bits : '0;
        // clear first, then set: an arriving bell beats a clear
        st_d.pend = ((st_q.pend & ~(wr_pend ? wmask : '0)) | bell_in) & IMPL_MASK;
        if (wr_unmsk) st_d.mask = st_q.mask & ~wmask;
        if (wr_mset)  st_d.mask = st_q.mask | wmask;
        st_d.watch = watch_in & IMPL_MASK;
        st_d.irq   = |(st_q.pend & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= IMPL_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_watch) bus_rdata = st_q.watch;
        if (rd_pend)  bus_rdata = st_q.pend;
        if (rd_mask)  bus_rdata = st_q.mask;
    end

    assign trig_out = st_q.fire;
    assign irq_out  = st_q.irq;
    assign mask_q   = st_q.mask;
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       bell_in,
    input logic [10:0]       trig_out,
    input logic [10:0]       watch_out,
    input logic              irq_out,
    input logic [31:0]       mask_q
);
    localparam int WW = ADDR_W - 2;

    // R1
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == '0);

    // R2
    fire_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out != '0) |-> ($past(bus_we) && $past(bus_addr[ADDR_W-1:2]) == WW'(W_FIRE)
                              && trig_out == gather($past(bus_wdata))));

    // R4
    bell_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bell_in & IMPL_MASK) != '0) |=> ((gather($past(bell_in)) & ~watch_out) == '0));

    // R6
    mset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[ADDR_W-1:2] == WW'(W_MSET))
        |=> ((mask_q & $past(bus_wdata) & IMPL_MASK) == ($past(bus_wdata) & IMPL_MASK)));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(watch_out & ~gather(mask_q))));
endmodule

bind ipi_hub ipi_hub_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bell_in   (bell_in),
    .trig_out  (trig_out),
    .watch_out (watch_out),
    .irq_out   (irq_out),
    .mask_q    (mask_q)
);

// File: tb/ipi_hub_tb.sv
module ipi_hub_tb;
    localparam logic [31:0] IMPL = 32'h0F0F0301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] bell_in = '0;
    logic [31:0] watch_in = '0;
    logic [10:0] trig_out;
    logic [10:0] watch_out;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_pend, m_mask, m_watch;
    logic [10:0] m_fire;
    logic        m_irq;

    always #5 clk = ~clk;

    ipi_hub u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bell_in(bell_in),
        .watch_in(watch_in), .trig_out(trig_out), .watch_out(watch_out),
        .irq_out(irq_out)
    );

    function automatic logic [10:0] pick(input logic [31:0] w);
        int pos [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
        logic [10:0] r;
        for (int i = 0; i < 11; i++) r[i] = w[pos[i]];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a[4:2])
            3'd1:    return m_watch;
            3'd4:    return m_pend;
            3'd5:    return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle; checks every output after the edge
    task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                        input logic [31:0] bell, input logic [31:0] watch, input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; bell_in = bell; watch_in = watch;
        @(posedge clk);
        m_irq  = |(m_pend & ~m_mask);
        m_fire = (we && a[4:2] == 3'd0) ? pick(d) : 11'h0;
        m_pend = ((m_pend & ~((we && a[4:2] == 3'd4) ? (d & IMPL) : 32'h0)) | bell) & IMPL;
        if (we && a[4:2] == 3'd6) m_mask = m_mask & ~(d & IMPL);
        if (we && a[4:2] == 3'd7) m_mask = m_mask | (d & IMPL);
        m_watch = watch & IMPL;
        #1;
        check({"R2 trig_out ", tag}, 32'(trig_out), 32'(m_fire));
        check({"R9 watch_out ", tag}, 32'(watch_out), 32'(pick(m_pend)));
        check({"R7 irq_out ", tag}, 32'(irq_out), 32'(m_irq));
        check({"R1/R10 rdata ", tag}, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_pend = '0; m_mask = IMPL; m_watch = '0; m_fire = '0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 5'h14;
        #1;
        // R5 reset value of the mask
        check("R5 mask after reset", bus_rdata, 32'h0F0F0301);
        check("R7 irq after reset", 32'(irq_out), 32'h0);
        check("R9 watch_out after reset", 32'(watch_out), 32'h0);

        // R2 fire all bits, then pulse ends; register reads zero
        step(1'b1, 5'h00, 32'hFFFFFFFF, 32'h0, 32'h0, "fire all");
        check("R2 fire all pattern", 32'(trig_out), 32'h7FF);
        step(1'b0, 5'h00, 32'h0, 32'h0, 32'h0, "fire idle");
        check("R2 pulse ended", 32'(trig_out), 32'h0);
        step(1'b1, 5'h00, 32'h0F000001, 32'h0, 32'h0, "fire sparse");
        check("R2 sparse pattern", 32'(trig_out), 32'h781);

        // R3 bell sets, R1 reserved bell bits dropped
        step(1'b0, 5'h10, 32'h0, 32'hF0000100, 32'h0, "bell");
        check("R3 bell latched", bus_rdata, 32'h00000100);
        step(1'b0, 5'h10, 32'h0, 32'h0, 32'h0, "bell hold");
        check("R3 sticky", bus_rdata, 32'h00000100);
        check("R9 channel 1", 32'(watch_out), 32'h2);

        // R6 unmask, R7 irq the cycle after
        step(1'b1, 5'h18, 32'hFFFFFFFF, 32'h0, 32'h0, "unmask");
        check("R6 unmask read zero", bus_rdata, 32'h0);
        step(1'b0, 5'h14, 32'h0, 32'h0, 32'h0, "mask read");
        check("R6 mask cleared", bus_rdata, 32'h0);
        check("R7 irq raised", 32'(irq_out), 32'h1);

        // R4 set wins over clear
        step(1'b1, 5'h10, 32'h00000100, 32'h00000100, 32'h0, "collide");
        check("R4 set wins", bus_rdata, 32'h00000100);
        // R3 write 0 keeps, write 1 clears
        step(1'b1, 5'h10, 32'h0, 32'h0, 32'h0, "w0");
        check("R3 write zero keeps", bus_rdata, 32'h00000100);
        step(1'b1, 5'h10, 32'hFFFFFFFF, 32'h0, 32'h0, "w1c");
        check("R3 cleared", bus_rdata, 32'h0);

        // R5 direct mask write ignored
        step(1'b1, 5'h14, 32'h0F0F0301, 32'h0, 32'h0, "mask write");
        check("R5 mask write ignored", bus_rdata, 32'h0);
        // R6 mask-set
        step(1'b1, 5'h1C, 32'h01000001, 32'h0, 32'h0, "mset");
        step(1'b0, 5'h14, 32'h0, 32'h0, 32'h0, "mset read");
        check("R6 mask set bits", bus_rdata, 32'h01000001);

        // R8 watch register, writes ignored
        step(1'b1, 5'h04, 32'h0, 32'hFFFFFFFF & 32'h0, 32'hFFFFFFFF, "watch");
        check("R8 watch value", bus_rdata, 32'h0F0F0301);
        // R10 unmapped offset
        step(1'b0, 5'h08, 32'h0, 32'h0, 32'h0, "hole");
        check("R10 hole reads zero", bus_rdata, 32'h0);

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [2:0] w;
            w = 3'($urandom_range(0, 7));
            step(1'($urandom), {w, 2'b00}, $urandom,
                 $urandom & $urandom & $urandom, $urandom, "random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule